// File: doc/BRIEF.md
# Posit Word Decoder

This block takes one posit word of `N` bits, whose exponent field has a fixed width `ES`, and splits it into its parts. The parts are the sign, the signed regime value `k`, the exponent, the fraction left-aligned in a fixed-width field, and the number of fraction bits that are really present. Two flags mark the all-zero word and the single exception pattern. A negative word is two's-complemented before its fields are parsed.

The regime is a run of equal bits of any length, so every field boundary after it moves from word to word. The exponent can be cut short, and the fraction can be missing altogether. The decoder finds the run length, drops the run and its terminating bit, and then reads the exponent and the fraction from the bits that remain.

One register stage with a valid/ready handshake on both sides sits between the input word and the decoded fields. The defaults are `N=16` and `ES=3`. `ES=0` is also supported.

Top module: `posit_decoder`

## Requirements
- R1: `out_sign` equals bit `N-1` of the accepted word. When that bit is 1 (and the word is not the exception pattern), the other fields describe the two's complement of the word, taken modulo 2^N.
- R2: Call the bits below the sign the body, and let the run be the longest stretch of equal bits starting at body bit `N-2`. A run of m zeros gives `out_k` = -m. A run of m ones gives `out_k` = m-1.
- R3: The exponent is the `ES` bits that follow the bit ending the run, with the first of them as its most significant bit. For `ES=0`, `out_exp` is 0.
- R4: The fraction is every bit left after the exponent. `out_frac_len` gives how many there are, and `out_frac` holds them starting at its MSB, with zeros below them.
- R5: Fewer than `ES` bits may remain after the run and its terminating bit. In that case the missing low exponent bits read as 0 and `out_frac_len` is 0. When the run reaches bit 0, it has no terminating bit.
- R6: `out_zero` is 1 only for the all-zero word, and then `out_k`, `out_exp`, `out_frac` and `out_frac_len` are 0.
- R7: `out_nar` is 1 only for the word 1 followed by N-1 zeros, and then `out_k`, `out_exp`, `out_frac` and `out_frac_len` are 0.
- R8: `in_ready` is 1 whenever the output register is empty or `out_ready` is 1. A word is taken only in a cycle where `in_valid` and `in_ready` are both 1. Words come out in the order they went in, with none lost and none duplicated.
- R9: While `out_valid` is 1 and `out_ready` is 0, every output stays unchanged.
- R10: With N=16 and ES=3, the word 0_0001_101_11011101 decodes to k=-3, e=5, fraction 221/256 with 8 bits. The word 0_110_011_000101000 decodes to k=1, e=3, fraction 40/512 with 9 bits, and 256^k·2^e·(1+f) equals 2208.
- R11: After a synchronous reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Decoder can take a word |
| in_word | input | N | Posit word |
| out_valid | output | 1 | Decoded fields are held |
| out_ready | input | 1 | Consumer takes the fields |
| out_sign | output | 1 | Sign bit of the word |
| out_zero | output | 1 | Word is zero |
| out_nar | output | 1 | Word is the exception pattern |
| out_k | output | $clog2(N)+1 | Signed regime value |
| out_exp | output | max(ES,1) | Exponent |
| out_frac | output | N-3-ES | Left-aligned fraction |
| out_frac_len | output | $clog2(N-2-ES) | Number of fraction bits present |

## Verification
A wrong run count or a wrong post-run shift puts the wrong value on `out_k` and misplaces `out_exp` and `out_frac`. This shows up one cycle after the word is accepted, and only for the run lengths that are wrong, so every word of the default configuration is swept, along with every word of an 8-bit `ES=0` instance. Errors in the negation or the flags appear on the negative half of the code space or on the two special words. A handshake fault shows as a held output that changes during a stall, or as a word dropped or repeated compared with the order in which words were sent.

// File: rtl/posit_dec_pkg.sv
package posit_dec_pkg;

    // Class bits captured alongside the decoded fields
    typedef struct packed {
        logic sign;
        logic zero;
        logic nar;
    } pd_class_t;

    // Widest fraction: sign, a two-bit regime and the exponent are always spent
    function automatic int frac_bits(input int n, input int es);
        return n - 3 - es;
    endfunction

    function automatic int exp_bits(input int es);
        return (es > 0) ? es : 1;
    endfunction

endpackage

// File: rtl/posit_magnitude.sv
module posit_magnitude #(
    parameter int N = 16
) (
    input  logic [N-1:0] word,
    output logic [N-2:0] body
);
    logic [N-1:0] neg;

    always_comb begin
        neg  = word[N-1] ? (~word + 1'b1) : word;
        body = neg[N-2:0];
    end
endmodule

// File: rtl/posit_regime_scan.sv
module posit_regime_scan #(
    parameter int N  = 16,
    localparam int BW = N - 1,
    localparam int MW = $clog2(BW + 1),
    localparam int KW = MW + 1
) (
    input  logic [BW-1:0]        body,
    output logic signed [KW-1:0] k,
    output logic [BW-1:0]        rest,
    output logic [MW-1:0]        avail
);
    logic [MW-1:0] run_len;
    logic          open;
    logic          full;

    always_comb begin
        run_len = '0;
        open    = 1'b1;
        for (int i = BW - 1; i >= 0; i--) begin
            if (open && (body[i] == body[BW-1]))
                run_len = run_len + 1'b1;
            else
                open = 1'b0;
        end
    end

    always_comb begin
        full = (run_len == MW'(BW));
        if (body[BW-1])
            k = $signed({1'b0, run_len}) - KW'(1);
        else
            k = -$signed({1'b0, run_len});
        if (full) begin
            rest  = '0;
            avail = '0;
        end else begin
            rest  = body << (run_len + 1'b1);
            avail = MW'(BW - 1) - run_len;
        end
    end
endmodule

// File: rtl/posit_field_split.sv
module posit_field_split #(
    parameter int N  = 16,
    parameter int ES = 3,
    localparam int BW = N - 1,
    localparam int MW = $clog2(BW + 1),
    localparam int EW = posit_dec_pkg::exp_bits(ES),
    localparam int FW = posit_dec_pkg::frac_bits(N, ES),
    localparam int LW = $clog2(FW + 1)
) (
    input  logic [BW-1:0] rest,
    input  logic [MW-1:0] avail,
    output logic [EW-1:0] exp_f,
    output logic [FW-1:0] frac,
    output logic [LW-1:0] frac_len
);
    logic [BW-1:0] after_exp;

    generate
        if (ES > 0) begin : g_exp
            always_comb begin
                exp_f     = EW'(rest >> (BW - ES));
                after_exp = rest << ES;
            end
        end else begin : g_noexp
            always_comb begin
                exp_f     = '0;
                after_exp = rest;
            end
        end
    endgenerate

    always_comb begin
        frac = FW'(after_exp >> (BW - FW));
        if (avail > MW'(ES))
            frac_len = LW'(avail - MW'(ES));
        else
            frac_len = '0;
    end
endmodule

// File: rtl/posit_decoder.sv
module posit_decoder #(
    parameter int N  = 16,
    parameter int ES = 3,
    localparam int BW = N - 1,
    localparam int MW = $clog2(BW + 1),
    localparam int KW = MW + 1,
    localparam int EW = posit_dec_pkg::exp_bits(ES),
    localparam int FW = posit_dec_pkg::frac_bits(N, ES),
    localparam int LW = $clog2(FW + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [N-1:0]         in_word,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic                 out_sign,
    output logic                 out_zero,
    output logic                 out_nar,
    output logic signed [KW-1:0] out_k,
    output logic [EW-1:0]        out_exp,
    output logic [FW-1:0]        out_frac,
    output logic [LW-1:0]        out_frac_len
);
    import posit_dec_pkg::*;

    logic [BW-1:0]        body;
    logic signed [KW-1:0] k_raw;
    logic [BW-1:0]        rest;
    logic [MW-1:0]        avail;
    logic [EW-1:0]        exp_raw;
    logic [FW-1:0]        frac_raw;
    logic [LW-1:0]        len_raw;
    pd_class_t            cls_d, cls_q;
    logic                 special;
    logic                 take;

    posit_magnitude #(.N(N)) u_mag (
        .word (in_word),
        .body (body)
    );

    posit_regime_scan #(.N(N)) u_regime (
        .body  (body),
        .k     (k_raw),
        .rest  (rest),
        .avail (avail)
    );

    posit_field_split #(.N(N), .ES(ES)) u_split (
        .rest     (rest),
        .avail    (avail),
        .exp_f    (exp_raw),
        .frac     (frac_raw),
        .frac_len (len_raw)
    );

    always_comb begin
        cls_d.sign = in_word[N-1];
        cls_d.zero = (in_word == '0);
        cls_d.nar  = (in_word == {1'b1, {(N-1){1'b0}}});
        special    = cls_d.zero | cls_d.nar;
    end

    assign in_ready = ~out_valid | out_ready;
    assign take     = in_valid & in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            cls_q        <= '0;
            out_k        <= '0;
            out_exp      <= '0;
            out_frac     <= '0;
            out_frac_len <= '0;
        end else if (take) begin
            out_valid    <= 1'b1;
            cls_q        <= cls_d;
            out_k        <= special ? '0 : k_raw;
            out_exp      <= special ? '0 : exp_raw;
            out_frac     <= special ? '0 : frac_raw;
            out_frac_len <= special ? '0 : len_raw;
        end else if (out_ready) begin
            out_valid    <= 1'b0;
        end
    end

    assign out_sign = cls_q.sign;
    assign out_zero = cls_q.zero;
    assign out_nar  = cls_q.nar;

    // R8: an accepted word is presented on the next cycle
    a_r8_accept: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    // R8: a consumed result with nothing new behind it empties the stage
    a_r8_drain: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !in_valid) |=> !out_valid);

    // R9: stalled outputs hold
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_k) && $stable(out_exp)
            && $stable(out_frac) && $stable(out_frac_len) && $stable(out_sign)));

    // R1: sign follows the top bit of the accepted word
    a_r1_sign: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_sign == $past(in_word[N-1])));

    // R6/R7: the two special words never coincide
    a_r7_excl: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_zero && out_nar));

    // R7: exception output carries empty fields
    a_r7_fields: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_nar) |-> (out_k == '0 && out_frac_len == '0 && out_sign));

    // R6: zero output carries empty fields
    a_r6_fields: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_zero) |-> (out_k == '0 && out_exp == '0 && out_frac == '0 && !out_sign));

    // R4: fraction length never exceeds the field
    a_r4_len: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(out_frac_len) <= FW));
endmodule

// File: tb/posit_decoder_test.sv
`timescale 1ns/1ps
module posit_decoder_test;
    localparam int N  = 16;
    localparam int ES = 3;
    localparam int FW = N - 3 - ES;
    localparam int N2  = 8;
    localparam int ES2 = 0;
    localparam int FW2 = N2 - 3 - ES2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // main instance
    logic        in_valid = 1'b0, out_ready = 1'b0;
    logic        in_ready, out_valid, out_sign, out_zero, out_nar;
    logic [N-1:0] in_word = '0;
    logic signed [4:0] out_k;
    logic [2:0]   out_exp;
    logic [FW-1:0] out_frac;
    logic [3:0]   out_frac_len;

    posit_decoder #(.N(N), .ES(ES)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
        .out_sign(out_sign), .out_zero(out_zero), .out_nar(out_nar),
        .out_k(out_k), .out_exp(out_exp), .out_frac(out_frac),
        .out_frac_len(out_frac_len));

    // ES=0 instance
    logic        v2 = 1'b0;
    logic        rdy2, ov2, s2, z2, nar2;
    logic [N2-1:0] w2 = '0;
    logic signed [3:0] k2;
    logic [0:0]   e2;
    logic [FW2-1:0] f2;
    logic [2:0]   l2;

    posit_decoder #(.N(N2), .ES(ES2)) uut_es0 (
        .clk(clk), .rst(rst), .in_valid(v2), .in_ready(rdy2),
        .in_word(w2), .out_valid(ov2), .out_ready(1'b1),
        .out_sign(s2), .out_zero(z2), .out_nar(nar2),
        .out_k(k2), .out_exp(e2), .out_frac(f2), .out_frac_len(l2));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Arithmetic reference model
    task automatic model(input int n, input int es, input longint w,
                         output bit sg, output bit z, output bit nr,
                         output int k, output int e, output longint fr, output int fl,
                         output bit trunc);
        longint full = longint'(1) << n;
        longint mag, body, rest;
        int fw = n - 3 - es;
        int m, avail;
        bit lead, go;
        sg = ((w >> (n - 1)) & 1) != 0;
        z  = (w == 0);
        nr = (w == (longint'(1) << (n - 1)));
        k = 0; e = 0; fr = 0; fl = 0; trunc = 0;
        if (z || nr) return;
        mag  = sg ? (full - w) % full : w;
        body = mag % (longint'(1) << (n - 1));
        lead = ((body >> (n - 2)) & 1) != 0;
        m = 0; go = 1;
        for (int i = n - 2; i >= 0; i--) begin
            if (go && ((((body >> i) & 1) != 0) == lead)) m++;
            else go = 0;
        end
        k = lead ? m - 1 : -m;
        avail = (m >= n - 1) ? 0 : n - 2 - m;
        rest  = body % (longint'(1) << avail);
        if (avail >= es) begin
            e  = int'(rest >> (avail - es));
            fl = avail - es;
            fr = (rest % (longint'(1) << fl)) << (fw - fl);
        end else begin
            e = int'(rest << (es - avail));
            trunc = 1;
        end
    endtask

    task automatic check_main(input logic [N-1:0] w);
        bit sg, z, nr, tr; int k, e, fl; longint fr;
        string rx, rf;
        model(N, ES, longint'(w), sg, z, nr, k, e, fr, fl, tr);
        rx = tr ? "R5" : "R3";
        rf = tr ? "R5" : "R4";
        chk(out_sign == sg, "R1", "sign", out_sign, sg);
        chk(int'(out_k) == k, "R2", "k", out_k, k);
        chk(int'(out_exp) == e, rx, "exp", out_exp, e);
        chk(longint'(out_frac) == fr, rf, "frac", out_frac, fr);
        chk(int'(out_frac_len) == fl, rf, "frac_len", out_frac_len, fl);
        chk(out_zero == z, "R6", "zero", out_zero, z);
        chk(out_nar == nr, "R7", "nar", out_nar, nr);
    endtask

    logic [N-1:0] sent [$];

    task automatic send_one(input logic [N-1:0] w);
        @(negedge clk);
        in_word = w; in_valid = 1'b1; out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        logic [7:0] lfsr;
        int idx;
        bit stall_prev;
        logic signed [4:0] sk; logic [2:0] se; logic [FW-1:0] sf; logic [3:0] sl;
        real v, scale;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk(out_valid == 1'b0, "R11", "out_valid", out_valid, 0);
        chk(in_ready == 1'b1, "R11", "in_ready", in_ready, 1);
        chk(ov2 == 1'b0, "R11", "es0 out_valid", ov2, 0);

        // R10: the two worked vectors
        send_one(16'b0_0001_101_11011101);
        chk(out_valid, "R10", "valid", out_valid, 1);
        chk(out_k == -5'sd3, "R10", "k", out_k, -3);
        chk(out_exp == 3'd5, "R10", "exp", out_exp, 5);
        chk(out_frac_len == 4'd8, "R10", "len", out_frac_len, 8);
        chk(out_frac == 10'(221 << 2), "R10", "frac", out_frac, 221 << 2);
        send_one(16'b0_110_011_000101000);
        chk(out_k == 5'sd1, "R10", "k", out_k, 1);
        chk(out_exp == 3'd3, "R10", "exp", out_exp, 3);
        chk(out_frac_len == 4'd9, "R10", "len", out_frac_len, 9);
        scale = 1.0;
        for (int i = 0; i < int'(out_k); i++) scale = scale * 256.0;
        for (int i = 0; i < int'(out_exp); i++) scale = scale * 2.0;
        v = scale * (1.0 + real'(out_frac) / 1024.0);
        chk(v > 2207.999 && v < 2208.001, "R10", "value", longint'(v), 2208);
        // R8: output empties when drained
        @(negedge clk);
        chk(out_valid == 1'b0, "R8", "drained", out_valid, 0);

        // Exhaustive sweep with back-pressure (R1..R9)
        lfsr = 8'hA5; idx = 0; stall_prev = 0;
        while (idx < 65536 || sent.size() != 0) begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            in_valid  = (idx < 65536);
            in_word   = N'(idx);
            out_ready = (lfsr[2:0] != 3'd0);
            #1;
            if (stall_prev) begin
                chk(out_valid && out_k == sk && out_exp == se && out_frac == sf
                    && out_frac_len == sl, "R9", "stall hold", out_k, sk);
            end
            stall_prev = out_valid && !out_ready;
            sk = out_k; se = out_exp; sf = out_frac; sl = out_frac_len;
            chk(in_ready == (!out_valid || out_ready), "R8", "in_ready", in_ready,
                !out_valid || out_ready);
            if (out_valid && out_ready) begin
                if (sent.size() == 0)
                    chk(0, "R8", "unexpected output", 1, 0);
                else
                    check_main(sent.pop_front());
            end
            if (in_valid && in_ready) begin
                sent.push_back(in_word);
                idx++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk(sent.size() == 0 && out_valid == 1'b0, "R8", "all consumed", sent.size(), 0);

        // ES=0 exhaustive sweep (R3 with no exponent field)
        for (int w = 0; w < 256; w++) begin
            bit sg, z, nr, tr; int k, e, fl; longint fr;
            @(negedge clk);
            w2 = N2'(w); v2 = 1'b1;
            @(negedge clk);
            v2 = 1'b0;
            model(N2, ES2, longint'(w), sg, z, nr, k, e, fr, fl, tr);
            chk(ov2, "R8", "es0 valid", ov2, 1);
            chk(s2 == sg, "R1", "es0 sign", s2, sg);
            chk(int'(k2) == k, "R2", "es0 k", k2, k);
            chk(e2 == 1'b0, "R3", "es0 exp", e2, 0);
            chk(longint'(f2) == fr, "R4", "es0 frac", f2, fr);
            chk(int'(l2) == fl, "R4", "es0 len", l2, fl);
            chk(z2 == z, "R6", "es0 zero", z2, z);
            chk(nar2 == nr, "R7", "es0 nar", nar2, nr);
        end

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule